// File: doc/BRIEF.md
# Serial EEPROM Target with Region Locking

This block is a synthesizable target-side model of a 256-byte two-wire serial EEPROM. It oversamples the clock and data lines with the system clock and detects START and STOP conditions. Its device address is matched against three strap inputs. It supports single-byte and 16-byte page writes. On the read side it supports reads from the current address, random reads that begin with a dummy write of the word address, and sequential reads that continue while the controller acknowledges each byte. Data is driven onto the bus only by pulling it low through an output enable. The controller side resolves the bus as a wired-AND.

A second address group lets the controller lock the lower half of the array, addresses 00h to 7Fh. One command sets a lock that can be cleared again. Another sets a lock that cannot be cleared. The same address patterns with the read bit set report the state of each lock through the acknowledge bit. A write-protect pin blocks all array writes and all lock commands. A STOP after written data or after a lock command starts an internal write cycle. During that cycle the device acknowledges no address.

Top module: `eep_i2c_slave`

## Requirements
- R1: An address byte 1010 s2 s1 s0 R/W is acknowledged when s2..s0 equal strap_i and no write cycle is running. An address byte outside both address groups is not acknowledged.
- R2: sda_oe_o changes only while SCL is low, and it is 0 out of reset and whenever the device is not driving an acknowledge or a 0 data bit.
- R3: Data bytes that follow the word address are acknowledged and stored at the next STOP. The low 4 address bits advance and wrap inside the 16-byte page, so a later byte at the same slot replaces an earlier one.
- R4: A random read (write address, word address, repeated START, read address) returns the byte at the word address. Sequential reads advance the address by one after each byte and wrap from FFh to 00h. A read started with no word address continues from the address counter.
- R5: While wp_i is 1, data bytes are still acknowledged but nothing is stored.
- R6: Lock commands are address bytes 0110 b2 b1 b0 0. Low bits 001 set the reversible lock, 011 clear it, and low bits equal to strap_i set the permanent lock, checked in that priority order. A command is acknowledged only while wp_i is 0 and takes effect at the following STOP. A START before the STOP cancels it.
- R7: While either lock is set, writes to 00h..7Fh are acknowledged but not stored. Writes to 80h..FFh are unaffected.
- R8: Query bytes 0110 b2 b1 b0 1 with low bits 001 or 011 report the reversible lock, and with low bits equal to strap_i report the permanent lock. The answer is ACK when the lock is clear and NACK when it is set.
- R9: The permanent lock is never cleared. The clear command removes only the reversible lock, and only while the permanent lock is clear.
- R10: A START during any transfer abandons it and discards the page data not yet committed, but the address counter keeps its value.
- R11: A STOP after at least one data byte, or after an accepted lock command, starts a write cycle of WR_CYCLES clocks. During this cycle every address is left unacknowledged and SDA is never driven.
- R12: After reset all 256 bytes read FFh, both locks are clear and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved wired-AND) |
| sda_oe_o | output | 1 | Pull-down enable for the data line |
| strap_i | input | 3 | Device address strap bits |
| wp_i | input | 1 | Write-protect pin, 1 blocks writes and lock commands |

## Verification
The checker watches four things on every clock. The data pull-down only toggles while the bus clock is low. The line stays released for the whole write cycle. The permanent lock never falls, and the reversible lock only falls while the permanent lock is clear. Any lock change follows a cycle in which the protect pin was low. Which bytes end up stored, page wrap order, sequential and current-address reads, acknowledge decisions across the whole address space, busy polling, and the effect of START aborts can only be shown by the bench's bus transactions compared against its own memory and lock model.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_CMD, ST_RDATA, ST_RACK, ST_HALT
  } eep_state_e;

  typedef enum logic [1:0] {
    CMD_NONE, CMD_SET_REV, CMD_CLR_REV, CMD_SET_PERM
  } eep_cmd_e;

  localparam logic [3:0] GRP_MEM  = 4'b1010;
  localparam logic [3:0] GRP_LOCK = 4'b0110;
  localparam logic [2:0] LOW_SET  = 3'b001;
  localparam logic [2:0] LOW_CLR  = 3'b011;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC-2:0], sda_i};
      scl_q    <= scl_sync[SYNC-1];
      sda_q    <= sda_sync[SYNC-1];
    end
  end

  assign scl_s      = scl_sync[SYNC-1];
  assign sda_o      = sda_sync[SYNC-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edges while clock stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [7:0]  RST_VAL = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eep_wbuf.sv
module eep_wbuf #(
  parameter int unsigned PAGE = 16,
  localparam int unsigned PG_W = $clog2(PAGE)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            wr_i,
  input  logic [PG_W-1:0] idx_i,
  input  logic [7:0]      data_i,
  input  logic [PG_W-1:0] rd_idx_i,
  output logic [7:0]      rd_data_o,
  output logic            rd_vld_o
);
  logic [7:0] data_q [PAGE];
  logic [PAGE-1:0] vld_q;

  for (genvar g = 0; g < PAGE; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[g]  <= 1'b0;
      end else if (wr_i && idx_i == PG_W'(g)) begin
        data_q[g] <= data_i;
        vld_q[g]  <= 1'b1;
      end
    end
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
endmodule

// File: rtl/eep_lock.sv
module eep_lock
  import eep_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     apply_i,
  input  eep_cmd_e cmd_i,
  input  logic     wp_i,
  output logic     rev_o,
  output logic     perm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rev_o  <= 1'b0;
      perm_o <= 1'b0;
    end else if (apply_i && !wp_i) begin
      case (cmd_i)
        CMD_SET_REV:  rev_o  <= 1'b1;
        CMD_CLR_REV:  if (!perm_o) rev_o <= 1'b0;
        CMD_SET_PERM: perm_o <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGE      = 16,
  parameter int unsigned WR_CYCLES = 1000,
  parameter int unsigned SYNC      = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int unsigned PG_W   = $clog2(PAGE);
  localparam int unsigned CNT_W  = $clog2(WR_CYCLES + 1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [PG_W-1:0]   PG_ONE   = {{(PG_W-1){1'b0}}, 1'b1};
  localparam logic [PG_W-1:0]   PG_LAST  = PG_W'(PAGE - 1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]  CNT_LOAD = CNT_W'(WR_CYCLES);

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  eep_state_e state, nxt_q;
  eep_cmd_e cmd_pend, cmd_sel;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, rd_byte;
  logic ack_ph, mack, wdata_seen;
  logic [ADDR_W-1:0] addr_cnt, mem_waddr;
  logic [ADDR_W-PG_W-1:0] page_base;
  logic [CNT_W-1:0] busy_cnt;
  logic busy, commit_act, blk_wp;
  logic [PG_W-1:0] commit_idx;
  logic buf_wr, buf_clr, buf_vld;
  logic [7:0] buf_q, mem_rdata;
  logic mem_we, rev, perm, lock_q, lock_apply, busy_start, commit_start;
  logic byte_done, mem_hit, lock_hit;

  eep_bus_cond #(.SYNC(SYNC)) u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  eep_wbuf #(.PAGE(PAGE)) u_wbuf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .wr_i(buf_wr),
    .idx_i(addr_cnt[PG_W-1:0]), .data_i(shreg),
    .rd_idx_i(commit_idx), .rd_data_o(buf_q), .rd_vld_o(buf_vld)
  );

  eep_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(buf_q),
    .raddr_i(addr_cnt), .rdata_o(mem_rdata)
  );

  eep_lock u_lock (
    .clk_i, .rst_ni, .apply_i(lock_apply), .cmd_i(cmd_pend), .wp_i,
    .rev_o(rev), .perm_o(perm)
  );

  always_comb begin
    cmd_sel = CMD_NONE;
    if (shreg[3:1] == LOW_SET)      cmd_sel = CMD_SET_REV;
    else if (shreg[3:1] == LOW_CLR) cmd_sel = CMD_CLR_REV;
    else if (shreg[3:1] == strap_i) cmd_sel = CMD_SET_PERM;
  end

  assign busy         = (busy_cnt != '0);
  assign byte_done    = scl_fall & ~ack_ph & (bit_cnt == 4'd8) & ~start_ev & ~stop_ev;
  assign mem_hit      = (shreg[7:4] == GRP_MEM) && (shreg[3:1] == strap_i) && !busy;
  assign lock_hit     = (shreg[7:4] == GRP_LOCK) && !busy && (cmd_sel != CMD_NONE);
  assign lock_q       = (cmd_sel == CMD_SET_PERM) ? perm : rev;
  assign buf_wr       = byte_done && (state == ST_WDATA);
  assign buf_clr      = start_ev & ~busy;
  assign commit_start = stop_ev && (state == ST_WDATA) && wdata_seen;
  assign lock_apply   = stop_ev && (state == ST_CMD) && (cmd_pend != CMD_NONE);
  assign busy_start   = commit_start | lock_apply;
  assign mem_waddr    = {page_base, commit_idx};
  assign mem_we       = commit_act & buf_vld & ~blk_wp &
                        ~((rev | perm) & ~mem_waddr[ADDR_W-1]);

  // write cycle timer and one-slot-per-clock commit of the page buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt   <= '0;
      commit_act <= 1'b0;
      commit_idx <= '0;
      blk_wp     <= 1'b0;
    end else begin
      if (busy_start)   busy_cnt <= CNT_LOAD;
      else if (busy)    busy_cnt <= busy_cnt - CNT_ONE;
      if (commit_start) begin
        commit_act <= 1'b1;
        commit_idx <= '0;
        blk_wp     <= wp_i;
      end else if (commit_act) begin
        commit_idx <= commit_idx + PG_ONE;
        if (commit_idx == PG_LAST) commit_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      nxt_q      <= ST_IDLE;
      cmd_pend   <= CMD_NONE;
      bit_cnt    <= '0;
      shreg      <= '0;
      rd_byte    <= '0;
      ack_ph     <= 1'b0;
      mack       <= 1'b0;
      wdata_seen <= 1'b0;
      addr_cnt   <= '0;
      page_base  <= '0;
      sda_oe_o   <= 1'b0;
    end else if (start_ev || stop_ev) begin
      state      <= start_ev ? ST_DEV : ST_IDLE;
      bit_cnt    <= '0;
      ack_ph     <= 1'b0;
      sda_oe_o   <= 1'b0;
      cmd_pend   <= CMD_NONE;
      wdata_seen <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WADDR, ST_WDATA, ST_CMD: begin
          if (scl_rise && !ack_ph && bit_cnt != 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end
          if (byte_done) begin
            ack_ph <= 1'b1;
            case (state)
              ST_DEV: begin
                if (mem_hit) begin
                  sda_oe_o <= 1'b1;
                  nxt_q    <= shreg[0] ? ST_RDATA : ST_WADDR;
                end else if (lock_hit && !shreg[0] && !wp_i) begin
                  sda_oe_o <= 1'b1;
                  cmd_pend <= cmd_sel;
                  nxt_q    <= ST_CMD;
                end else if (lock_hit && shreg[0] && !lock_q) begin
                  sda_oe_o <= 1'b1;
                  nxt_q    <= ST_HALT;
                end else begin
                  ack_ph <= 1'b0;
                  state  <= ST_HALT;
                end
              end
              ST_WADDR: begin
                sda_oe_o <= 1'b1;
                addr_cnt <= shreg[ADDR_W-1:0];
                nxt_q    <= ST_WDATA;
              end
              ST_WDATA: begin
                sda_oe_o   <= 1'b1;
                wdata_seen <= 1'b1;
                if (!wdata_seen) page_base <= addr_cnt[ADDR_W-1:PG_W];
                addr_cnt   <= {addr_cnt[ADDR_W-1:PG_W], addr_cnt[PG_W-1:0] + PG_ONE};
                nxt_q      <= ST_WDATA;
              end
              default: begin
                sda_oe_o <= 1'b1;
                nxt_q    <= ST_CMD;
              end
            endcase
          end else if (scl_fall && ack_ph) begin
            ack_ph  <= 1'b0;
            bit_cnt <= '0;
            state   <= nxt_q;
            if (nxt_q == ST_RDATA) begin
              rd_byte  <= mem_rdata;
              sda_oe_o <= ~mem_rdata[7];
            end else begin
              sda_oe_o <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_oe_o <= 1'b0;
              addr_cnt <= addr_cnt + ADDR_ONE;
              bit_cnt  <= '0;
              state    <= ST_RACK;
            end else begin
              sda_oe_o <= ~rd_byte[6];
              rd_byte  <= {rd_byte[6:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack    <= ~sda_s;
            bit_cnt <= 4'd1;
          end else if (scl_fall && bit_cnt == 4'd1) begin
            bit_cnt <= '0;
            if (mack) begin
              rd_byte  <= mem_rdata;
              sda_oe_o <= ~mem_rdata[7];
              state    <= ST_RDATA;
            end else begin
              state <= ST_HALT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic wp_i,
  input logic sda_oe_o,
  input logic busy,
  input logic rev,
  input logic perm
);
  // R2: pull-down toggles only in the clock-low phase
  assert_sda_scl_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  // R11: line stays released through the write cycle
  assert_busy_silent_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);

  // R9: permanent lock is sticky
  assert_perm_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(perm) |-> perm);

  // R9: reversible lock falls only while permanent lock is clear
  assert_rev_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rev) |-> !$past(perm));

  // R6: lock state changes only after protect pin was low
  assert_lock_wp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(rev) || $rose(perm)) |-> !$past(wp_i));
endmodule

bind eep_i2c_slave eep_i2c_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .wp_i(wp_i),
  .sda_oe_o(sda_oe_o), .busy(busy), .rev(rev), .perm(perm)
);

// File: tb/tb_eep_i2c_slave.sv
module tb_eep_i2c_slave;
  localparam int Q = 5;
  localparam logic [7:0] DW = 8'hAA;
  localparam logic [7:0] DR = 8'hAB;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire sda_bus = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  eep_i2c_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .wp_i(wp)
  );

  int checks = 0, fails = 0;
  logic [7:0] exp_mem [256];
  logic rev_m = 1'b0, perm_m = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; half(); scl = 1'b1; half(); m_sda = 1'b0; half(); scl = 1'b0; half();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; half(); scl = 1'b1; half(); m_sda = 1'b1; half();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; half(); scl = 1'b1; half(); half(); scl = 1'b0; half();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; half(); scl = 1'b1; half(); b = sda_bus; half(); scl = 1'b0; half();
  endtask

  task automatic wb(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(x);
    ack = ~x;
  endtask

  task automatic rb(input logic give_ack, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) begin recv_bit(x); d[i] = x; end
    send_bit(~give_ack);
  endtask

  task automatic poll(output int n);
    logic ack;
    n = 0;
    do begin
      i2c_start(); wb(DW, ack); n++;
    end while (!ack && n < 100);
    i2c_stop();
  endtask

  // page write with model update; returns poll attempts
  task automatic wr_page(input logic [7:0] a, input int n, input logic [7:0] seed, output int np);
    logic ack;
    logic [7:0] d;
    i2c_start(); wb(DW, ack); chk("R1 write addr ack", ack, 1);
    wb(a, ack);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 7);
      wb(d, ack);
      chk("R3/R5/R7 data ack", ack, 1);
      if (!wp && !(!a[7] && (rev_m || perm_m)))
        exp_mem[{a[7:4], 4'(a[3:0] + 4'(k))}] = d;
    end
    i2c_stop();
    poll(np);
  endtask

  task automatic rd_seq(input logic [7:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    i2c_start(); wb(DW, ack); wb(a, ack);
    i2c_start(); wb(DR, ack); chk({req, " read addr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      rb(k != n - 1, d);
      chk(req, d, exp_mem[8'(a + 8'(k))]);
    end
    i2c_stop();
  endtask

  task automatic cur_read(input logic [7:0] a, input string req);
    logic ack;
    logic [7:0] d;
    i2c_start(); wb(DR, ack); rb(1'b0, d); i2c_stop();
    chk(req, d, exp_mem[a]);
  endtask

  task automatic cmd(input logic [7:0] b, output logic ack);
    int n;
    i2c_start(); wb(b, ack); i2c_stop();
    if (ack && !b[0]) poll(n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack, e;
    logic [3:0] hi;
    logic [2:0] lo;
    int n;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state and full sequential read
    chk("R12 sda released", sda_oe, 0);
    rd_seq(8'h00, 256, "R12 R4 erased contents");

    // R1 R6 write-direction address sweep, protect pin low
    for (int d = 0; d < 128; d++) begin
      hi = 4'(d >> 3); lo = 3'(d);
      e = (hi == 4'hA && lo == strap) ||
          (hi == 4'h6 && (lo == 3'b001 || lo == 3'b011 || lo == strap));
      i2c_start(); wb(8'(d << 1), ack);
      chk("R1 R6 address ack sweep", ack, e);
    end
    i2c_start(); i2c_stop();
    // R8 queries with both locks clear (also shows R6 START cancelled commands)
    for (int l = 0; l < 8; l++) begin
      e = (l == 1 || l == 3 || l == int'(strap));
      i2c_start(); wb({4'h6, 3'(l), 1'b1}, ack);
      chk("R8 query sweep clear", ack, e);
    end
    i2c_stop();
    // R6 commands refused while protect pin high
    wp = 1'b1;
    for (int l = 0; l < 8; l++) begin
      i2c_start(); wb({4'h6, 3'(l), 1'b0}, ack);
      chk("R6 command nack with wp", ack, 0);
    end
    i2c_stop();
    wp = 1'b0;

    // R3 byte write, R11 busy polling
    wr_page(8'h90, 1, 8'h5A, n);
    chk("R11 busy nack on first poll", n > 1, 1);
    rd_seq(8'h90, 1, "R3 R4 byte write readback");
    // R3 page wrap with overwrite
    wr_page(8'hC5, 18, 8'h11, n);
    rd_seq(8'hC0, 16, "R3 page wrap");
    // R4 sequential wrap FF->00 and current-address read
    wr_page(8'hFE, 2, 8'h40, n);
    wr_page(8'h00, 3, 8'h60, n);
    rd_seq(8'hFC, 8, "R4 sequential wrap");
    cur_read(8'h04, "R4 current address");

    // R5 protect pin blocks data
    wp = 1'b1;
    wr_page(8'h30, 3, 8'h23, n);
    wp = 1'b0;
    rd_seq(8'h30, 3, "R5 wp blocked");

    // R6 R8 reversible lock
    cmd(8'h62, ack); chk("R6 set reversible ack", ack, 1); rev_m = 1'b1;
    i2c_start(); wb(8'h63, ack); i2c_stop(); chk("R8 query reversible set", ack, 0);
    i2c_start(); wb(8'h67, ack); i2c_stop(); chk("R8 alt query reversible set", ack, 0);
    i2c_start(); wb(8'h6B, ack); i2c_stop(); chk("R8 query permanent clear", ack, 1);
    wr_page(8'h10, 2, 8'h81, n);
    wr_page(8'h80, 2, 8'h91, n);
    rd_seq(8'h10, 2, "R7 lower half locked");
    rd_seq(8'h80, 2, "R7 upper half open");
    cmd(8'h66, ack); chk("R9 clear reversible ack", ack, 1); rev_m = 1'b0;
    i2c_start(); wb(8'h63, ack); i2c_stop(); chk("R9 reversible cleared", ack, 1);
    wr_page(8'h10, 2, 8'hA1, n);
    rd_seq(8'h10, 2, "R7 lower half reopened");

    // R9 permanent lock
    cmd(8'h62, ack); rev_m = 1'b1;
    cmd(8'h6A, ack); chk("R6 set permanent ack", ack, 1); perm_m = 1'b1;
    i2c_start(); wb(8'h6B, ack); i2c_stop(); chk("R8 query permanent set", ack, 0);
    cmd(8'h66, ack);
    i2c_start(); wb(8'h63, ack); i2c_stop(); chk("R9 clear ignored under permanent", ack, 0);
    wr_page(8'h00, 1, 8'h33, n);
    rd_seq(8'h00, 1, "R9 lower half still locked");

    // R10 START abort keeps counter, drops data
    i2c_start(); wb(DW, ack); wb(8'hA0, ack); wb(8'h77, ack); wb(8'h78, ack);
    i2c_start(); i2c_stop();
    poll(n);
    chk("R10 R11 no write cycle after abort", n, 1);
    cur_read(8'hA2, "R10 counter retained");
    rd_seq(8'hA0, 2, "R10 data discarded");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule